// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces the drive waveforms for a multiplexed liquid-crystal panel that has four common electrodes and a parameterized number of segment electrodes (eighteen by default), scanned at 1/4 duty, so up to 72 pixels are addressed. Each output is a 3-bit level code. An analog bias network outside the block turns that code into one of the voltages ground, 1/3, 1/2, 2/3 or full supply. The block takes a segment image with one bit per pixel, a bias-scheme select, a display-blank control and a periodic time-base tick.

The sequencer scans the commons one slot at a time. A frame consists of a positive half, in which COM0 to COM3 are each selected once, followed by a negative half that repeats the four slots with every level mirrored, so the net voltage on every pixel averages to zero. Two bias schemes are offered. In the 1/2 scheme the commons use three levels and the segments use two. In the 1/3 scheme both the commons and the segments use four levels. Each scheme has its own slot length in ticks. With a 1 kHz tick and the default of two ticks per slot, a slot lasts 2 ms and the eight-slot frame repeats at 62.5 Hz. After reset, and until the scan starts, the panel sees the non-select waveform only.

Top module: `lcd_wave_seq`

## Requirements
- R1: After reset, every common carries its non-select level and every segment carries its non-select level for the positive half, whatever the image. These are 2 and 4 in the 1/2 scheme, and 1 and 3 in the 1/3 scheme. The first tick after reset starts the scan at slot 0 of the positive half; that tick is not counted toward the slot length.
- R2: Level codes are 0 = ground, 1 = 1/3, 2 = 1/2, 3 = 2/3 and 4 = full. No output ever carries a code above 4.
- R3: Slots run COM0, COM1, COM2, COM3 in the positive half, then the same four in the negative half, then repeat. A slot lasts HALF_SLOT_TICKS ticks when `bias_third` = 0 and THIRD_SLOT_TICKS ticks when it is 1. Exactly one common is selected while the scan runs, and the scan moves only on a tick.
- R4: In the 1/2 scheme the selected common is 4 in the positive half and 0 in the negative half. Non-selected commons are 2.
- R5: In the 1/2 scheme a lit segment is 0 in the positive half and 4 in the negative half. An unlit segment is 4 in the positive half and 0 in the negative half. No other segment code appears.
- R6: In the 1/3 scheme the selected common is 4 in the positive half and 0 in the negative half. Non-selected commons are 1 in the positive half and 3 in the negative half.
- R7: In the 1/3 scheme a lit segment is 0 in the positive half and 4 in the negative half. An unlit segment is 3 in the positive half and 1 in the negative half.
- R8: The pixel for segment s on common c is bit `s*4 + c` of `seg_image`. A segment is lit during the slot of common c exactly when that bit is 1.
- R9: While `disp_off` is 1, all common and segment outputs are 0. The scan keeps advancing underneath, so clearing the bit resumes at the slot the timing has reached.
- R10: A change of `bias_third` restarts the scan in the following cycle at slot 0 of the positive half with the tick count cleared, so the new scheme begins with a full slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse |
| bias_third | input | 1 | 0 selects the 1/2 scheme, 1 selects the 1/3 scheme |
| disp_off | input | 1 | 1 blanks all outputs to ground |
| seg_image | input | N_SEG*4 | Pixel bits, bit s*4+c for segment s on common c |
| com_lvl | output | 12 | Level code of common c in bits c*3+2..c*3 |
| seg_lvl | output | N_SEG*3 | Level code of segment s in bits s*3+2..s*3 |

## Verification
The scan is walked tick by tick through two full frames in each bias scheme. This is repeated with an all-dark image, an all-lit image, an alternating-bit image and two irregular arithmetic patterns. The uniform images separate the lit and unlit levels of each half. The irregular ones expose any swap between the segment and common index in the image mapping. Switching the scheme partway through a slot, blanking during a running scan, and resetting in each scheme separate a true restart and a running time base from stale timing state.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int LCD_COMS = 4;
    localparam int SLOT_W   = $clog2(LCD_COMS);
    localparam int LVL_W    = 3;

    typedef enum logic [LVL_W-1:0] {
        LV_GND   = 3'd0,
        LV_THIRD = 3'd1,
        LV_HALF  = 3'd2,
        LV_TWO3  = 3'd3,
        LV_FULL  = 3'd4
    } lvl_e;

    typedef enum logic {
        BIAS_HALF  = 1'b0,
        BIAS_THIRD = 1'b1
    } bias_e;

    typedef struct packed {
        logic              run;
        logic              neg;
        logic [SLOT_W-1:0] slot;
        bias_e             bias;
    } scan_s;

    function automatic lvl_e com_sel_level(input logic neg);
        return neg ? LV_GND : LV_FULL;
    endfunction

    function automatic lvl_e com_idle_level(input bias_e bias, input logic neg);
        if (bias == BIAS_HALF) begin
            return LV_HALF;
        end
        return neg ? LV_TWO3 : LV_THIRD;
    endfunction

    function automatic lvl_e seg_level(input bias_e bias, input logic neg, input logic lit);
        if (lit) begin
            return neg ? LV_FULL : LV_GND;
        end
        if (bias == BIAS_HALF) begin
            return neg ? LV_GND : LV_FULL;
        end
        return neg ? LV_THIRD : LV_TWO3;
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_seq_pkg::*;
#(
    parameter int HALF_SLOT_TICKS  = 2,
    parameter int THIRD_SLOT_TICKS = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  bias_sel,
    output scan_s scan
);

    localparam int MAX_TICKS = (HALF_SLOT_TICKS > THIRD_SLOT_TICKS) ? HALF_SLOT_TICKS : THIRD_SLOT_TICKS;
    localparam int CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LCD_COMS - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] slot_end;
    bias_e            bias_in;
    logic             mode_moved;

    always_comb begin
        bias_in    = bias_e'(bias_sel);
        mode_moved = (bias_in != scan.bias);
        slot_end   = (scan.bias == BIAS_THIRD) ? CNT_W'(THIRD_SLOT_TICKS - 1)
                                               : CNT_W'(HALF_SLOT_TICKS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan.run  <= 1'b0;
            scan.neg  <= 1'b0;
            scan.slot <= '0;
            scan.bias <= bias_in;
            tick_cnt  <= '0;
        end else if (mode_moved) begin
            scan.bias <= bias_in;
            scan.neg  <= 1'b0;
            scan.slot <= '0;
            tick_cnt  <= '0;
        end else if (tick) begin
            if (!scan.run) begin
                scan.run <= 1'b1;
            end else if (tick_cnt == slot_end) begin
                tick_cnt <= '0;
                if (scan.slot == LAST_SLOT) begin
                    scan.slot <= '0;
                    scan.neg  <= ~scan.neg;
                end else begin
                    scan.slot <= scan.slot + 1'b1;
                end
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
    import lcd_seq_pkg::*;
(
    input  scan_s                       scan,
    input  logic                        disp_off,
    output logic [LCD_COMS*LVL_W-1:0]   com_lvl
);

    for (genvar c = 0; c < LCD_COMS; c++) begin : g_com
        lvl_e lvl;
        always_comb begin
            if (disp_off) begin
                lvl = LV_GND;
            end else if (scan.run && (scan.slot == SLOT_W'(c))) begin
                lvl = com_sel_level(scan.neg);
            end else begin
                lvl = com_idle_level(scan.bias, scan.neg);
            end
        end
        assign com_lvl[c*LVL_W +: LVL_W] = lvl;
    end

endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
    import lcd_seq_pkg::*;
#(
    parameter int N_SEG = 18
) (
    input  scan_s                        scan,
    input  logic                         disp_off,
    input  logic [N_SEG*LCD_COMS-1:0]    image,
    output logic [N_SEG*LVL_W-1:0]       seg_lvl
);

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        logic [LCD_COMS-1:0] column;
        logic                lit;
        lvl_e                lvl;
        always_comb begin
            column = image[s*LCD_COMS +: LCD_COMS];
            lit    = scan.run && column[scan.slot];
            lvl    = disp_off ? LV_GND : seg_level(scan.bias, scan.neg, lit);
        end
        assign seg_lvl[s*LVL_W +: LVL_W] = lvl;
    end

endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
    import lcd_seq_pkg::*;
#(
    parameter int N_SEG            = 18,
    parameter int HALF_SLOT_TICKS  = 2,
    parameter int THIRD_SLOT_TICKS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       bias_third,
    input  logic                       disp_off,
    input  logic [N_SEG*LCD_COMS-1:0]  seg_image,
    output logic [LCD_COMS*LVL_W-1:0]  com_lvl,
    output logic [N_SEG*LVL_W-1:0]     seg_lvl
);

    scan_s scan;

    lcd_scan_timer #(
        .HALF_SLOT_TICKS  (HALF_SLOT_TICKS),
        .THIRD_SLOT_TICKS (THIRD_SLOT_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .bias_sel (bias_third),
        .scan     (scan)
    );

    lcd_com_drive u_com (
        .scan     (scan),
        .disp_off (disp_off),
        .com_lvl  (com_lvl)
    );

    lcd_seg_drive #(
        .N_SEG (N_SEG)
    ) u_seg (
        .scan     (scan),
        .disp_off (disp_off),
        .image    (seg_image),
        .seg_lvl  (seg_lvl)
    );

endmodule

// File: rtl/lcd_wave_seq_chk.sv
module lcd_wave_seq_chk
    import lcd_seq_pkg::*;
#(
    parameter int N_SEG = 18
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tick,
    input logic                       bias_third,
    input logic                       disp_off,
    input logic [LCD_COMS*LVL_W-1:0]  com_lvl,
    input logic [N_SEG*LVL_W-1:0]     seg_lvl,
    input scan_s                      scan
);

    logic                range_bad;
    logic                half_seg_bad;
    logic [LCD_COMS-1:0] com_extreme;
    logic                all_ground;
    logic                mode_step;

    always_comb begin
        range_bad    = 1'b0;
        half_seg_bad = 1'b0;
        for (int c = 0; c < LCD_COMS; c++) begin
            com_extreme[c] = (com_lvl[c*LVL_W +: LVL_W] == 3'd0) || (com_lvl[c*LVL_W +: LVL_W] == 3'd4);
            if (com_lvl[c*LVL_W +: LVL_W] > 3'd4) range_bad = 1'b1;
        end
        for (int s = 0; s < N_SEG; s++) begin
            if (seg_lvl[s*LVL_W +: LVL_W] > 3'd4) range_bad = 1'b1;
            if (!(seg_lvl[s*LVL_W +: LVL_W] == 3'd0 || seg_lvl[s*LVL_W +: LVL_W] == 3'd4)) half_seg_bad = 1'b1;
        end
        all_ground = (com_lvl == '0) && (seg_lvl == '0);
        mode_step  = (bias_e'(bias_third) != scan.bias);
    end

    assert_code_range_R2: assert property (@(posedge clk) disable iff (rst) !range_bad);

    assert_one_selected_R3: assert property (@(posedge clk) disable iff (rst)
        (scan.run && !disp_off) |-> ($countones(com_extreme) == 1));

    assert_slot_waits_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !mode_step) |=> ($stable(scan.slot) && $stable(scan.neg)));

    assert_idle_nonselect_R1: assert property (@(posedge clk) disable iff (rst)
        (!scan.run && !disp_off) |-> (com_extreme == '0));

    assert_half_seg_levels_R5: assert property (@(posedge clk) disable iff (rst)
        (!disp_off && scan.bias == BIAS_HALF) |-> !half_seg_bad);

    assert_blank_ground_R9: assert property (@(posedge clk) disable iff (rst)
        disp_off |-> all_ground);

    assert_mode_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_step && scan.run && !disp_off) |=> (com_lvl[LVL_W-1:0] == 3'd4));

endmodule

bind lcd_wave_seq lcd_wave_seq_chk #(.N_SEG(N_SEG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .bias_third (bias_third),
    .disp_off   (disp_off),
    .com_lvl    (com_lvl),
    .seg_lvl    (seg_lvl),
    .scan       (scan)
);

// File: tb/lcd_wave_seq_tb.sv
module lcd_wave_seq_tb;

    localparam int NS    = 18;
    localparam int NC    = 4;
    localparam int HALFT = 3;
    localparam int THRDT = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              bias_third = 1'b0;
    logic              disp_off = 1'b0;
    logic [NS*NC-1:0]  seg_image = '0;
    logic [NC*3-1:0]   com_lvl;
    logic [NS*3-1:0]   seg_lvl;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // reference model state
    logic m_run, m_neg, m_bias;
    int   m_slot, m_cnt;

    lcd_wave_seq #(
        .N_SEG            (NS),
        .HALF_SLOT_TICKS  (HALFT),
        .THIRD_SLOT_TICKS (THRDT)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .bias_third (bias_third),
        .disp_off   (disp_off),
        .seg_image  (seg_image),
        .com_lvl    (com_lvl),
        .seg_lvl    (seg_lvl)
    );

    always #4 clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            finish_run();
        end
    end

    function automatic logic [NS*NC-1:0] pattern(input int p);
        logic [NS*NC-1:0] v;
        for (int i = 0; i < NS*NC; i++) begin
            case (p)
                0: v[i] = 1'b0;
                1: v[i] = 1'b1;
                2: v[i] = i[0];
                3: v[i] = ((i*5 + i/4) % 3) == 0;
                default: v[i] = (((i/4) % 2) == 0) ^ ((i % 3) == 1);
            endcase
        end
        return v;
    endfunction

    function automatic logic [NC*3-1:0] exp_com();
        logic [NC*3-1:0] v;
        for (int c = 0; c < NC; c++) begin
            int lv;
            if (disp_off) lv = 0;
            else if (m_run && m_slot == c) lv = m_neg ? 0 : 4;
            else if (!m_bias) lv = 2;
            else lv = m_neg ? 3 : 1;
            v[c*3 +: 3] = 3'(lv);
        end
        return v;
    endfunction

    function automatic logic [NS*3-1:0] exp_seg();
        logic [NS*3-1:0] v;
        for (int s = 0; s < NS; s++) begin
            int lv;
            logic on;
            on = m_run && seg_image[s*NC + m_slot];
            if (disp_off) lv = 0;
            else if (on) lv = m_neg ? 4 : 0;
            else if (!m_bias) lv = m_neg ? 0 : 4;
            else lv = m_neg ? 1 : 3;
            v[s*3 +: 3] = 3'(lv);
        end
        return v;
    endfunction

    task automatic check_out(input string tag);
        logic [NC*3-1:0] ec;
        logic [NS*3-1:0] es;
        ec = exp_com();
        es = exp_seg();
        checks++;
        if (com_lvl !== ec) begin
            errors++;
            $display("FAIL %s com: actual=%h expected=%h", tag, com_lvl, ec);
        end
        checks++;
        if (seg_lvl !== es) begin
            errors++;
            $display("FAIL %s seg: actual=%h expected=%h", tag, seg_lvl, es);
        end
    endtask

    task automatic do_reset(input logic third);
        @(negedge clk);
        bias_third = third;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_run = 1'b0; m_neg = 1'b0; m_slot = 0; m_cnt = 0; m_bias = third;
    endtask

    task automatic pulse_tick();
        int len;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        len = m_bias ? THRDT : HALFT;
        if (!m_run) begin
            m_run = 1'b1;
        end else if (m_cnt == len - 1) begin
            m_cnt = 0;
            if (m_slot == NC - 1) begin
                m_slot = 0;
                m_neg  = ~m_neg;
            end else begin
                m_slot++;
            end
        end else begin
            m_cnt++;
        end
    endtask

    task automatic switch_bias(input logic third);
        @(negedge clk);
        bias_third = third;
        @(negedge clk);
        m_bias = third; m_slot = 0; m_neg = 1'b0; m_cnt = 0;
    endtask

    initial begin
        // R1: pre-start non-select waveform in 1/2 scheme with a lit image
        seg_image = pattern(1);
        do_reset(1'b0);
        check_out("R1 R2 reset half");
        repeat (5) @(negedge clk);
        check_out("R1 idle without tick");
        pulse_tick();
        check_out("R1 R3 first tick starts scan");

        // R3 R4 R5 R8: two frames per image in the 1/2 scheme
        for (int p = 0; p < 5; p++) begin
            seg_image = pattern(p);
            @(negedge clk);
            check_out("R4 R5 R8 half image");
            for (int t = 0; t < 2*2*NC*HALFT; t++) begin
                pulse_tick();
                check_out("R3 R4 R5 R8 half scan");
            end
        end

        // R10: change scheme part-way through a slot
        pulse_tick();
        check_out("R3 pre-switch");
        switch_bias(1'b1);
        check_out("R10 restart into third");

        // R3 R6 R7 R8: two frames per image in the 1/3 scheme
        for (int p = 0; p < 5; p++) begin
            seg_image = pattern(p);
            @(negedge clk);
            check_out("R6 R7 R8 third image");
            for (int t = 0; t < 2*2*NC*THRDT; t++) begin
                pulse_tick();
                check_out("R3 R6 R7 R8 third scan");
            end
        end

        // R10: switch back inside the negative half
        for (int t = 0; t < NC*THRDT + 1; t++) pulse_tick();
        check_out("R7 negative half before switch");
        switch_bias(1'b0);
        check_out("R10 restart into half");
        for (int t = 0; t < 2*NC*HALFT; t++) begin
            pulse_tick();
            check_out("R10 R3 half after restart");
        end

        // R9: blanking while the scan keeps running
        seg_image = pattern(3);
        @(negedge clk);
        disp_off = 1'b1;
        @(negedge clk);
        check_out("R9 blank");
        for (int t = 0; t < 7; t++) begin
            pulse_tick();
            check_out("R9 blank during ticks");
        end
        disp_off = 1'b0;
        @(negedge clk);
        check_out("R9 resume at advanced slot");
        for (int t = 0; t < NC*HALFT; t++) begin
            pulse_tick();
            check_out("R9 R3 after blank");
        end

        // R1: reset in the 1/3 scheme
        seg_image = pattern(1);
        do_reset(1'b1);
        check_out("R1 reset third");
        pulse_tick();
        check_out("R1 R6 R7 start third");
        for (int t = 0; t < 2*NC*THRDT; t++) begin
            pulse_tick();
            check_out("R3 R7 third after reset");
        end

        finish_run();
    end

endmodule